// File: doc/BRIEF.md
# Indirect Byte Register Window Bridge

This block puts a byte-wide internal register space behind one 32-bit host register. The host writes one word holding an internal address, a data byte and a direction flag. The bridge then runs the access on an internal request/ready port and raises a busy flag in the same word while the access is open. A read is split into phases. The host posts the address with the direction flag clear. It then polls busy, and once busy drops it collects the returned byte from the top byte of the same word.

The internal side holds a request level together with stable address, direction and data until the responder pulses ready. The responder can therefore be slow or run a variable number of cycles per access. A host write that arrives while an access is open is dropped. The read byte keeps its value until the next read completes.

Top module: `ibr_window_bridge`

## Requirements
- R1: After reset the whole window word reads zero and the internal request is low.
- R2: A host write with window bit 16 set, accepted while not busy, opens an internal write in the next cycle. The request is high with the direction output 1, the address taken from window bits [7:0] and the data taken from window bits [15:8].
- R3: A host write with bit 16 clear opens an internal read of the address in bits [7:0], with the direction output 0. When that read completes, the returned byte appears in window bits [31:24] in the cycle after ready.
- R4: Window bit 23 (busy) is 1 from the cycle after the accepted host write. While busy is 1, the internal request stays high and address, direction and data stay stable.
- R5: Busy and the request drop in the cycle after a clock edge at which ready is sampled high while the request is high.
- R6: A host write arriving while busy is 1 is ignored. The echoed command and the open internal access are unchanged, and no extra access follows.
- R7: Window bits [31:24] change only on a completed read. Writes, ignored writes and idle cycles leave them unchanged.
- R8: Window bits [16:0] echo the last accepted command: address in [7:0], data in [15:8], direction in bit 16. Bits [22:17] read zero.
- R9: A ready pulse while no request is open has no effect on busy, the read byte or the echoed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the host and internal ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the window word |
| host_wdata | input | 32 | Host write word: address, data, direction |
| host_rdata | output | 32 | Window word: echoed command, busy, read byte |
| int_req | output | 1 | Internal access request, held until ready |
| int_we | output | 1 | Internal direction: 1 write, 0 read |
| int_addr | output | 8 | Internal register address |
| int_wdata | output | 8 | Internal write data byte |
| int_rdata | input | 8 | Internal read data, valid with ready |
| int_ready | input | 1 | Internal completion pulse |

## Verification
An accepted host write shows up on the internal port and in the busy bit one cycle after the edge that takes it. A ready sampled at an edge clears busy and loads the read byte by the following cycle. The bench model applies the same inputs at each rising edge and compares every output at the next falling edge, so each result is checked in the cycle it is due. The responder waits between zero and eight cycles before giving ready, which moves the completion edge across that range. Directed checks sample the echo and the read byte right after writes sent while busy and after stray ready pulses, before any later stimulus can mask them.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_OPEN = 1'b1
   } seq_state_e;

   function automatic int unsigned field_top(input int unsigned lsb, input int unsigned width);
      return lsb + width - 1;
   endfunction
endpackage

// File: rtl/ibr_cmd_decode.sv
module ibr_cmd_decode #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CMD_W = ADDR_W + DATA_W + 1
) (
   input  logic [CMD_W-1:0]  cmd_word,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic              cmd_we
);
   localparam int unsigned DATA_LSB = ADDR_W;
   localparam int unsigned WE_POS   = ADDR_W + DATA_W;

   always_comb begin
      cmd_addr = cmd_word[ADDR_W-1:0];
      cmd_data = cmd_word[WE_POS-1:DATA_LSB];
      cmd_we   = cmd_word[WE_POS];
   end
endmodule

// File: rtl/ibr_access_seq.sv
module ibr_access_seq
   import ibr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic [ADDR_W-1:0] new_addr,
   input  logic [DATA_W-1:0] new_data,
   input  logic              new_we,
   input  logic              int_ready,
   output logic              busy,
   output logic              done,
   output logic              int_req,
   output logic              int_we,
   output logic [ADDR_W-1:0] int_addr,
   output logic [DATA_W-1:0] int_wdata
);
   seq_state_e        state_q;
   seq_state_e        state_d;
   logic              accept;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              we_q;

   assign busy    = (state_q == SEQ_OPEN);
   assign accept  = start_wr && (state_q == SEQ_IDLE);
   assign done    = (state_q == SEQ_OPEN) && int_ready;
   assign int_req = busy;
   assign int_we    = we_q;
   assign int_addr  = addr_q;
   assign int_wdata = data_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: if (start_wr)  state_d = SEQ_OPEN;
         SEQ_OPEN: if (int_ready) state_d = SEQ_IDLE;
         default:                 state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         we_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q <= new_addr;
            data_q <= new_data;
            we_q   <= new_we;
         end
      end
   end

   AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && !busy) |=> (int_req && int_addr == $past(new_addr)
                               && int_we == $past(new_we) && int_wdata == $past(new_data))); // R2
   AST_OPEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !int_ready) |=> (busy && $stable(int_addr) && $stable(int_we) && $stable(int_wdata))); // R4
   AST_READY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && int_ready) |=> !busy); // R5
   AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_wr) |=> ($stable(int_addr) && $stable(int_we) && $stable(int_wdata))); // R6
   AST_STRAY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_wr) |=> !busy); // R9
endmodule

// File: rtl/ibr_rd_capture.sv
module ibr_rd_capture #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic              is_write,
   input  logic [DATA_W-1:0] int_rdata,
   output logic [DATA_W-1:0] rd_byte
);
   logic load;
   assign load = done && !is_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rd_byte <= '0;
      else if (load) rd_byte <= int_rdata;
   end

   AST_RD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !is_write) |=> (rd_byte == $past(int_rdata))); // R3
   AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && !is_write) |=> $stable(rd_byte)); // R7
endmodule

// File: rtl/ibr_window_bridge.sv
module ibr_window_bridge
   import ibr_pkg::*;
#(
   parameter int unsigned WIN_W     = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned BUSY_POS  = 23,
   parameter int unsigned RDATA_LSB = 24,
   parameter bit          ECHO_CMD  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [WIN_W-1:0]  host_wdata,
   output logic [WIN_W-1:0]  host_rdata,
   output logic              int_req,
   output logic              int_we,
   output logic [ADDR_W-1:0] int_addr,
   output logic [DATA_W-1:0] int_wdata,
   input  logic [DATA_W-1:0] int_rdata,
   input  logic              int_ready
);
   localparam int unsigned WE_POS    = ADDR_W + DATA_W;
   localparam int unsigned CMD_W     = WE_POS + 1;
   localparam int unsigned RDATA_TOP = field_top(RDATA_LSB, DATA_W);

   if (BUSY_POS <= WE_POS)    begin : g_bad_busy  $error("busy bit overlaps command fields"); end
   if (RDATA_LSB <= BUSY_POS) begin : g_bad_rdlsb $error("read byte overlaps busy bit"); end
   if (RDATA_TOP >= WIN_W)    begin : g_bad_width $error("read byte exceeds window width"); end

   logic [ADDR_W-1:0] dec_addr;
   logic [DATA_W-1:0] dec_data;
   logic              dec_we;
   logic              busy;
   logic              done;
   logic [DATA_W-1:0] rd_byte;
   logic              unused_hi;

   assign unused_hi = ^host_wdata[WIN_W-1:CMD_W];

   ibr_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .cmd_word (host_wdata[CMD_W-1:0]),
      .cmd_addr (dec_addr),
      .cmd_data (dec_data),
      .cmd_we   (dec_we)
   );

   ibr_access_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_wr  (host_wr),
      .new_addr  (dec_addr),
      .new_data  (dec_data),
      .new_we    (dec_we),
      .int_ready (int_ready),
      .busy      (busy),
      .done      (done),
      .int_req   (int_req),
      .int_we    (int_we),
      .int_addr  (int_addr),
      .int_wdata (int_wdata)
   );

   ibr_rd_capture #(.DATA_W(DATA_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (done),
      .is_write  (int_we),
      .int_rdata (int_rdata),
      .rd_byte   (rd_byte)
   );

   if (ECHO_CMD) begin : g_echo
      always_comb begin
         host_rdata                       = '0;
         host_rdata[ADDR_W-1:0]           = int_addr;
         host_rdata[WE_POS-1:ADDR_W]      = int_wdata;
         host_rdata[WE_POS]               = int_we;
         host_rdata[BUSY_POS]             = busy;
         host_rdata[RDATA_TOP:RDATA_LSB]  = rd_byte;
      end
   end else begin : g_no_echo
      always_comb begin
         host_rdata                       = '0;
         host_rdata[BUSY_POS]             = busy;
         host_rdata[RDATA_TOP:RDATA_LSB]  = rd_byte;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (host_rdata == '0 && !int_req)); // R1
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata[BUSY_POS-1:WE_POS+1] == '0); // R8
endmodule

// File: tb/ibr_window_bridge_tb.sv
module ibr_window_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        int_req, int_we;
   logic [7:0]  int_addr, int_wdata;
   logic [7:0]  int_rdata = '0;
   logic        int_ready = 1'b0;

   always #2.5 clk = ~clk;

   ibr_window_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .int_req(int_req), .int_we(int_we),
      .int_addr(int_addr), .int_wdata(int_wdata), .int_rdata(int_rdata),
      .int_ready(int_ready)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // internal responder memory
   logic [7:0] mem [256];
   int lat = 0;
   int wait_cnt = 0;
   bit stray_en = 1'b0;

   initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);

   always @(negedge clk) begin
      if (int_ready) begin
         int_ready = 1'b0;
      end else if (rst_n && int_req) begin
         if (wait_cnt >= lat) begin
            int_ready = 1'b1;
            int_rdata = mem[int_addr];
            if (int_we) mem[int_addr] = int_wdata;
            wait_cnt = 0;
         end else begin
            wait_cnt++;
         end
      end else if (stray_en) begin
         int_ready = 1'b1;
         int_rdata = 8'hEE;
      end
   end

   // behavioural reference model
   bit       m_busy;
   bit       m_we;
   int       m_addr, m_data, m_rd;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_we = 0; m_addr = 0; m_data = 0; m_rd = 0;
      end else if (m_busy) begin
         if (int_ready) begin
            m_busy = 0;
            if (!m_we) m_rd = int_rdata;
         end
      end else if (host_wr) begin
         m_busy = 1;
         m_addr = host_wdata[7:0];
         m_data = host_wdata[15:8];
         m_we   = host_wdata[16];
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(host_rdata[23] == m_busy, "R4 R5 busy bit", 32'(host_rdata[23]), 32'(m_busy));
         chk(int_req == m_busy, "R4 R5 request level", 32'(int_req), 32'(m_busy));
         chk(host_rdata[31:24] == 8'(m_rd), "R3 R7 read byte", 32'(host_rdata[31:24]), 32'(m_rd));
         chk(host_rdata[16:0] == {m_we, 8'(m_data), 8'(m_addr)}, "R8 R6 command echo",
             32'(host_rdata[16:0]), 32'({m_we, 8'(m_data), 8'(m_addr)}));
         chk(host_rdata[22:17] == '0, "R8 reserved bits", 32'(host_rdata[22:17]), 32'd0);
         if (m_busy)
            chk({int_we, int_wdata, int_addr} == {m_we, 8'(m_data), 8'(m_addr)}, "R2 internal port",
                32'({int_we, int_wdata, int_addr}), 32'({m_we, 8'(m_data), 8'(m_addr)}));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         report();
      end
   end

   task automatic host_write(input logic [31:0] w);
      @(negedge clk);
      host_wr = 1'b1;
      host_wdata = w;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic wait_idle;
      do @(negedge clk); while (host_rdata[23]);
   endtask

   function automatic logic [31:0] cmd(input bit we, input logic [7:0] d, input logic [7:0] a);
      return {15'h7E00, we, d, a};
   endfunction

   logic [7:0] keep;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(host_rdata == '0, "R1 window after reset", host_rdata, 32'd0);
      chk(int_req == 1'b0, "R1 request after reset", 32'(int_req), 32'd0);

      // writes then reads at several latencies (R2, R3)
      for (int l = 0; l < 4; l++) begin
         lat = l;
         host_write(cmd(1'b1, 8'(8'hA0 + l), 8'(8'h10 + l)));
         wait_idle();
         host_write(cmd(1'b0, 8'h00, 8'(8'h10 + l)));
         wait_idle();
         chk(host_rdata[31:24] == 8'(8'hA0 + l), "R3 read back written byte",
             32'(host_rdata[31:24]), 32'(8'hA0 + l));
      end

      // R7: a write leaves the read byte unchanged
      keep = host_rdata[31:24];
      lat = 2;
      host_write(cmd(1'b1, 8'h5C, 8'h40));
      wait_idle();
      chk(host_rdata[31:24] == keep, "R7 read byte kept across write", 32'(host_rdata[31:24]), 32'(keep));

      // R6: writes while busy are dropped
      lat = 8;
      host_write(cmd(1'b0, 8'h00, 8'h05));
      host_write(cmd(1'b1, 8'h99, 8'h77));
      host_write(cmd(1'b0, 8'h00, 8'h33));
      chk(host_rdata[16:0] == 17'h00005, "R6 echo after ignored writes", 32'(host_rdata[16:0]), 32'h5);
      wait_idle();
      chk(host_rdata[31:24] == 8'(5 * 7 + 3), "R6 original read completes",
          32'(host_rdata[31:24]), 32'(5 * 7 + 3));
      chk(mem[8'h77] == 8'(8'h77 * 7 + 3), "R6 no extra write access", 32'(mem[8'h77]), 32'(8'h77 * 7 + 3));

      // R9: stray ready while idle
      keep = host_rdata[31:24];
      stray_en = 1'b1;
      repeat (6) @(negedge clk);
      stray_en = 1'b0;
      @(negedge clk);
      chk(host_rdata[23] == 1'b0, "R9 busy after stray ready", 32'(host_rdata[23]), 32'd0);
      chk(host_rdata[31:24] == keep, "R9 read byte after stray ready", 32'(host_rdata[31:24]), 32'(keep));

      // R5: back-to-back strobe held high, accepted only after busy clears
      lat = 1;
      @(negedge clk);
      host_wr = 1'b1;
      host_wdata = cmd(1'b0, 8'h00, 8'h21);
      repeat (4) @(negedge clk);
      host_wdata = cmd(1'b0, 8'h00, 8'h22);
      repeat (4) @(negedge clk);
      host_wr = 1'b0;
      wait_idle();
      chk(host_rdata[31:24] == 8'(8'h22 * 7 + 3), "R5 reissue after close",
          32'(host_rdata[31:24]), 32'(8'h22 * 7 + 3));

      // sweep of mixed accesses
      for (int k = 0; k < 40; k++) begin
         lat = k % 5;
         host_write(cmd(k[0], 8'(k * 13), 8'(k * 29)));
         if (k % 3 == 0) wait_idle();
      end
      wait_idle();
      repeat (3) @(negedge clk);
      report();
   end
endmodule